// File: doc/BRIEF.md
# Command Completion Counter with Level Interrupt

This block keeps the completion bookkeeping for one transfer channel. Every pulse on the completion input advances a 6-bit wrapping "done" count. Each such pulse also sets an "active" flag, and that flag drives a level-sensitive, active-high interrupt. Software reads a single status word to see the done count and the flag. It acknowledges by writing back the done count it has seen into a 6-bit "processed" field, with the active bit of the same write at zero. The interrupt drops only when that write leaves no gap between done and processed.

Because acknowledgement copies a counter value rather than clearing a bit, completions can never be lost. A completion that lands in the same cycle as the acknowledge write still counts, and it keeps the interrupt raised. A global enable input gates only the interrupt pin. The counters and the flag keep running whatever its value. All differences between the two counts are modulo 64.

Top module: `cmpl_count_irq`

## Requirements
- R1: While reset is high and in the first cycle after it, the status word reads 0 and the interrupt output is low.
- R2: A completion pulse sampled at a clock edge raises the done field (status bits 5:0) by one. The new value can be read from that edge on.
- R3: The done field wraps from 63 to 0, so 64 pulses return it to its starting value.
- R4: A write loads the processed field (status bits 21:16) from write-data bits 21:16. No write ever alters the done field.
- R5: A completion pulse sets the active flag (status bit 8) at the same edge.
- R6: A write with write-data bit 8 at 0, in a cycle with no completion, sets the flag to 0 when the written processed value equals the current done value.
- R7: Such a write leaves the flag at 1 when the written processed value differs from the current done value.
- R8: A write with write-data bit 8 at 1, in a cycle with no completion, leaves the flag unchanged. Software cannot raise the flag this way.
- R9: When a completion pulse and an acknowledge write share a cycle, the done count still increments, the processed field takes the written value, and the flag ends at 1.
- R10: The interrupt output equals the active flag AND the global enable input. The enable has no effect on the status word.
- R11: Status bits 7:6, 15:9 and 31:22 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data: bits 21:16 processed value, bit 8 keep-flag |
| rd_data | output | 32 | Status word: done 5:0, active 8, processed 21:16 |
| cmpl_pulse | input | 1 | One-cycle completion event |
| irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Level interrupt, active high |

## Verification
The hardest case to reach from the ports is a completion pulse in the very cycle that software writes the exact done value it just read. Only that case separates "increment kept, flag kept" from a design that lets the write win. The stimulus reaches it directly: it reads the done count, then presents the acknowledge write together with a pulse. It also reaches it at random, because the random phase draws correct acknowledges and pulses independently in the same cycle. A 64-pulse run with no acknowledge covers the wrap, where done equals processed again but the flag must stay set.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;

    localparam int CNT_W      = 6;
    localparam int WORD_W     = 32;
    localparam int DONE_LSB   = 0;
    localparam int ACT_BIT    = 8;
    localparam int PROC_LSB   = 16;
    localparam int CNT_MOD    = 1 << CNT_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t done;
        cnt_t proc_cnt;
        logic active;
    } status_t;

    typedef struct packed {
        logic strobe;
        cnt_t proc_cnt;
        logic keep_flag;
    } ack_req_t;

    function automatic logic [WORD_W-1:0] pack_status(status_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DONE_LSB +: CNT_W] = s.done;
        w[ACT_BIT]           = s.active;
        w[PROC_LSB +: CNT_W] = s.proc_cnt;
        return w;
    endfunction

    function automatic ack_req_t decode_write(logic en, cnt_t proc_field, logic keep);
        ack_req_t r;
        r.strobe    = en;
        r.proc_cnt  = proc_field;
        r.keep_flag = keep;
        return r;
    endfunction

endpackage

// File: rtl/cmpl_done_ctr.sv
module cmpl_done_ctr
    import cmpl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    output cnt_t done
);
    cnt_t done_q;

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= '0;
        else if (pulse)
            done_q <= done_q + cnt_t'(1);
    end

    assign done = done_q;
endmodule

// File: rtl/cmpl_ack_track.sv
module cmpl_ack_track
    import cmpl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pulse,
    input  cnt_t     done,
    input  ack_req_t req,
    output cnt_t     proc_cnt,
    output logic     active
);
    cnt_t proc_q;
    logic act_q;
    logic act_d;
    logic gap_after_ack;

    assign gap_after_ack = (done != req.proc_cnt);

    always_comb begin
        act_d = act_q;
        if (pulse)
            act_d = 1'b1;
        else if (req.strobe && !req.keep_flag)
            act_d = gap_after_ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            proc_q <= '0;
            act_q  <= 1'b0;
        end else begin
            if (req.strobe)
                proc_q <= req.proc_cnt;
            act_q <= act_d;
        end
    end

    assign proc_cnt = proc_q;
    assign active   = act_q;
endmodule

// File: rtl/cmpl_irq_gate.sv
module cmpl_irq_gate (
    input  logic active,
    input  logic enable,
    output logic irq
);
    assign irq = active & enable;
endmodule

// File: rtl/cmpl_count_irq.sv
module cmpl_count_irq
    import cmpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              cmpl_pulse,
    input  logic              irq_en,
    output logic              irq
);
    cnt_t     done_w;
    cnt_t     proc_w;
    logic     act_w;
    ack_req_t req_w;
    status_t  stat_w;

    assign req_w = decode_write(wr_en, wr_data[PROC_LSB +: CNT_W], wr_data[ACT_BIT]);

    cmpl_done_ctr u_done (
        .clk   (clk),
        .rst   (rst),
        .pulse (cmpl_pulse),
        .done  (done_w)
    );

    cmpl_ack_track u_ack (
        .clk      (clk),
        .rst      (rst),
        .pulse    (cmpl_pulse),
        .done     (done_w),
        .req      (req_w),
        .proc_cnt (proc_w),
        .active   (act_w)
    );

    cmpl_irq_gate u_gate (
        .active (act_w),
        .enable (irq_en),
        .irq    (irq)
    );

    always_comb begin
        stat_w.done     = done_w;
        stat_w.proc_cnt = proc_w;
        stat_w.active   = act_w;
    end

    assign rd_data = pack_status(stat_w);
endmodule

// File: rtl/cmpl_count_irq_chk.sv
module cmpl_count_irq_chk
    import cmpl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic              cmpl_pulse,
    input logic              irq_en,
    input logic              irq
);
    assert_done_step_R2: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse |=> rd_data[DONE_LSB +: CNT_W] == cnt_t'($past(rd_data[DONE_LSB +: CNT_W]) + 1));

    assert_done_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cmpl_pulse |=> $stable(rd_data[DONE_LSB +: CNT_W]));

    assert_proc_load_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[PROC_LSB +: CNT_W] == $past(wr_data[PROC_LSB +: CNT_W]));

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse |=> rd_data[ACT_BIT]);

    assert_keep_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[ACT_BIT] && !cmpl_pulse) |=> $stable(rd_data[ACT_BIT]));

    assert_coincide_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmpl_pulse) |=> (rd_data[ACT_BIT] && irq == irq_en));

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    assert_spare_zero_R11: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:22] == '0 && rd_data[15:9] == '0 && rd_data[7:6] == '0);
endmodule

bind cmpl_count_irq cmpl_count_irq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .cmpl_pulse (cmpl_pulse),
    .irq_en     (irq_en),
    .irq        (irq)
);

// File: tb/cmpl_count_irq_test.sv
`timescale 1ns/1ps
module cmpl_count_irq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cmpl_pulse = 1'b0;
    logic        irq_en = 1'b1;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [5:0] m_done = '0;
    logic [5:0] m_proc = '0;
    logic       m_flag = 1'b0;

    always #4 clk = ~clk;

    cmpl_count_irq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cmpl_pulse(cmpl_pulse), .irq_en(irq_en), .irq(irq)
    );

    function automatic logic [31:0] exp_word(logic [5:0] d, logic [5:0] p, logic f);
        return {10'b0, p, 7'b0, f, 2'b0, d};
    endfunction

    function automatic logic exp_flag(logic f, logic [5:0] d, logic ev, logic we, logic [31:0] wd);
        if (ev) return 1'b1;
        if (we && !wd[8]) return d != wd[21:16];
        return f;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        check({tag, " word R2 R4 R11"}, rd_data, exp_word(m_done, m_proc, m_flag));
        check({tag, " irq R10"}, {31'b0, irq}, {31'b0, m_flag & irq_en});
    endtask

    // One cycle: drive at negedge, check after the next edge.
    task automatic step(string tag, logic ev, logic we, logic [31:0] wd, logic ien);
        @(negedge clk);
        cmpl_pulse = ev; wr_en = we; wr_data = wd; irq_en = ien;
        @(posedge clk);
        m_flag = exp_flag(m_flag, m_done, ev, we, wd);
        if (we) m_proc = wd[21:16];
        if (ev) m_done = m_done + 6'd1;
        #1;
        check_outputs(tag);
    endtask

    function automatic logic [31:0] ack_word(logic [5:0] p, logic keep);
        return {10'b0, p, 7'b0, keep, 8'b0};
    endfunction

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] start;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("reset R1", rd_data, 32'h0);
        check("reset irq R1", {31'b0, irq}, 32'h0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("after reset R1", rd_data, 32'h0);

        // R2 R5: events count and set the flag
        step("evt R5", 1, 0, 0, 1);
        step("evt R2", 1, 0, 0, 1);
        step("evt R2", 1, 0, 0, 1);
        step("idle R2", 0, 0, 0, 1);
        // R7: ack with stale value keeps flag
        step("stale ack R7", 0, 1, ack_word(6'd1, 0), 1);
        check("stale ack flag R7", {31'b0, rd_data[8]}, 32'h1);
        // R6: exact ack clears
        step("exact ack R6", 0, 1, ack_word(m_done, 0), 1);
        check("exact ack flag R6", {31'b0, rd_data[8]}, 32'h0);
        // R8: keep bit write cannot raise flag
        step("keep write R8", 0, 1, ack_word(6'd9, 1), 1);
        check("keep write flag R8", {31'b0, rd_data[8]}, 32'h0);
        step("evt R5", 1, 0, 0, 1);
        step("keep write set R8", 0, 1, ack_word(m_done, 1), 1);
        check("keep write hold R8", {31'b0, rd_data[8]}, 32'h1);
        // R9: event coincides with exact ack
        step("coincide R9", 1, 1, ack_word(m_done, 0), 1);
        check("coincide flag R9", {31'b0, rd_data[8]}, 32'h1);
        check("coincide irq R9", {31'b0, irq}, 32'h1);
        // R10: enable low hides irq only
        step("ien low R10", 1, 0, 0, 0);
        check("ien low irq R10", {31'b0, irq}, 32'h0);
        check("ien low flag R10", {31'b0, rd_data[8]}, 32'h1);
        // R3: 64 events wrap
        start = m_done;
        for (int i = 0; i < 64; i++) step("wrap R3", 1, 0, 0, 1);
        check("wrap value R3", {26'b0, rd_data[5:0]}, {26'b0, start});
        step("ack after wrap R6", 0, 1, ack_word(m_done, 0), 1);
        // R11: spare bits written high still read zero
        step("spare R11", 0, 1, 32'hFFC0_FEC0 | ack_word(m_done, 0), 1);

        for (int i = 0; i < 3000; i++) begin
            logic ev, we, ien;
            logic [31:0] wd;
            ev  = ($urandom % 3) == 0;
            we  = ($urandom % 4) == 0;
            ien = ($urandom % 8) != 0;
            if ($urandom % 2) wd = ack_word(m_done, 1'b0);
            else wd = $urandom;
            step("random R2 R4 R6 R7 R8 R9", ev, we, wd, ien);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule